// File: doc/BRIEF.md
# Processor Status Flag Register with Stack Save and Restore

This block holds the eight condition flags of a small processor whose instruction word is a set of independent per-register operation fields. The register is rewritten on every rising clock edge. Each flag either takes a fresh value from its functional unit or is fed back unchanged, depending on the operation codes in the current word. The arithmetic itself happens elsewhere: the 18-bit accumulator result, the accumulator zero indication and the carry and zero indications of the three index compares arrive as inputs.

Three exact whole-word patterns give the flags a path to memory. In each of them the program-counter, accumulator, X and Y fields are all no-op. If the S field selects push or a top-of-stack access, the flags drive the external data bus instead of the internal bus, and the access is marked as a write. If the S field selects pop, the feedback loop is broken and the flags load from the external data bus. No other path writes the flags from outside.

Top module: `flag_unit`

## Requirements
- R1: While `rstN` is low all flags clear to 0. With no flag pattern decoded, `extBusOut` equals `intBus` and `flagDrive` is 0.
- R2: The accumulator zero flag (`flags[1]`) holds when the accumulator field `opWord[12:9]` is 0 (no-op) or 1 (store). For every other accumulator code it loads `aZeroIn` on the next edge.
- R3: The accumulator carry (`flags[0]`) loads `aSum[17]` when the accumulator code is 3 (add with carry) or 4 (shift left through carry). It loads `aSum[0]` for code 5 (shift right through carry). For every other code it holds.
- R4: X, Y and S use the fields `opWord[8:6]`, `opWord[5:3]` and `opWord[2:0]`, and their flags sit at `flags[3:2]`, `flags[5:4]` and `flags[7:6]` as {zero, carry}. Code 3 (compare) loads both flags from `idxCarryIn[i]` and `idxZeroIn[i]`, where index 0 is X, 1 is Y and 2 is S. Code 2 (load) loads only the zero flag. All other codes hold both flags.
- R5: A single word can update seven flags at once. With accumulator code 6 (exclusive-OR) and compare on X, Y and S, every flag except the accumulator carry changes.
- R6: For `opWord` equal to 16'h0004 (save flags) or 16'h0006 (flags to top of stack), `flagDrive` is 1 and `extBusOut` is {8'h00, flags}. The flags themselves hold.
- R7: For `opWord` equal to 16'h0005 (restore flags), the flags load `extBusIn[7:0]` on the next edge, and `extBusIn[15:8]` is ignored.
- R8: The patterns are exact 16-bit matches. Any word that differs in any bit, for example a push in S with a nonzero accumulator field, leaves `flagDrive` at 0 and the flags on their normal update path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opWord | input | 16 | Instruction word {P[15:13], A[12:9], X[8:6], Y[5:3], S[2:0]} |
| aSum | input | 18 | Extended accumulator result |
| aZeroIn | input | 1 | Accumulator result-is-zero indication |
| idxCarryIn | input | 3 | Compare carry for X, Y, S |
| idxZeroIn | input | 3 | Zero indication for X, Y, S |
| intBus | input | 16 | Internal data bus |
| extBusIn | input | 16 | External data bus read value |
| extBusOut | output | 16 | External data bus write value |
| flagDrive | output | 1 | Flags are the bus source; access is a write |
| flags | output | 8 | Current flag register |

## Verification
The assertions take for granted that `opWord`, `aSum` and the index indications are stable and known across each clock edge, and that `extBusIn` carries a defined value whenever the restore pattern is present. The bench changes every input only just after a rising edge. It draws field codes from the full range of each field and mixes exact pattern words with single-bit variants of them, so every input the properties sample is settled and defined.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int DATA_W   = 16;
  localparam int SUM_W    = 18;
  localparam int IDX_REGS = 3;
  localparam int FLAG_W   = 2 + 2 * IDX_REGS;

  localparam logic [3:0] A_NOA = 4'd0;
  localparam logic [3:0] A_STA = 4'd1;
  localparam logic [3:0] A_ADC = 4'd3;
  localparam logic [3:0] A_SLC = 4'd4;
  localparam logic [3:0] A_SRC = 4'd5;

  localparam logic [2:0] I_LOAD = 3'd2;
  localparam logic [2:0] I_CMP  = 3'd3;

  localparam logic [15:0] W_PUSHF = 16'h0004;
  localparam logic [15:0] W_POPF  = 16'h0005;
  localparam logic [15:0] W_FTOS  = 16'h0006;

  typedef enum logic [1:0] {
    CSEL_HOLD = 2'd0,
    CSEL_MSB  = 2'd1,
    CSEL_LSB  = 2'd2
  } carrySel_t;

  typedef struct packed {
    logic                aZeroLd;
    carrySel_t           aCarrySel;
    logic [IDX_REGS-1:0] idxCarryLd;
    logic [IDX_REGS-1:0] idxZeroLd;
    logic                popLoad;
    logic                flagDrive;
  } flagCtl_t;
endpackage

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] opWord,
  output flagCtl_t    ctl
);
  logic [3:0] aOp;
  logic [2:0] idxOp [IDX_REGS];

  assign aOp = opWord[12:9];

  genvar gi;
  generate
    for (gi = 0; gi < IDX_REGS; gi++) begin : g_idx
      // field order X, Y, S from high to low
      assign idxOp[gi] = opWord[3*(IDX_REGS-1-gi) +: 3];
      assign ctl.idxCarryLd[gi] = (idxOp[gi] == I_CMP);
      assign ctl.idxZeroLd[gi]  = (idxOp[gi] == I_CMP) || (idxOp[gi] == I_LOAD);
    end
  endgenerate

  always_comb begin
    ctl.aZeroLd = !((aOp == A_NOA) || (aOp == A_STA));
    unique case (aOp)
      A_ADC, A_SLC: ctl.aCarrySel = CSEL_MSB;
      A_SRC:        ctl.aCarrySel = CSEL_LSB;
      default:      ctl.aCarrySel = CSEL_HOLD;
    endcase
    ctl.popLoad   = (opWord == W_POPF);
    ctl.flagDrive = (opWord == W_PUSHF) || (opWord == W_FTOS);
  end

  // R8: save and restore are never decoded together
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.popLoad, ctl.flagDrive}));

  // R2: no-op and store on the accumulator never touch its zero flag
  assert_store_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((aOp == A_NOA) || (aOp == A_STA)) |-> !ctl.aZeroLd);

  // R6: a save word implies the flags stay in place
  assert_save_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flagDrive |-> (!ctl.aZeroLd && ctl.aCarrySel == CSEL_HOLD &&
                       ctl.idxCarryLd == '0 && ctl.idxZeroLd == '0));
endmodule

// File: rtl/flag_dpath.sv
module flag_dpath
  import flag_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  flagCtl_t            ctl,
  input  logic [SUM_W-1:0]    aSum,
  input  logic                aZeroIn,
  input  logic [IDX_REGS-1:0] idxCarryIn,
  input  logic [IDX_REGS-1:0] idxZeroIn,
  input  logic [DATA_W-1:0]   intBus,
  input  logic [DATA_W-1:0]   extBusIn,
  output logic [DATA_W-1:0]   extBusOut,
  output logic [FLAG_W-1:0]   flags
);
  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] flagLoop;
  logic [FLAG_W-1:0] flagNext;

  always_comb begin
    unique case (ctl.aCarrySel)
      CSEL_MSB: flagLoop[0] = aSum[SUM_W-1];
      CSEL_LSB: flagLoop[0] = aSum[0];
      default:  flagLoop[0] = flagQ[0];
    endcase
    flagLoop[1] = ctl.aZeroLd ? aZeroIn : flagQ[1];
  end

  genvar gi;
  generate
    for (gi = 0; gi < IDX_REGS; gi++) begin : g_idx
      assign flagLoop[2+2*gi] = ctl.idxCarryLd[gi] ? idxCarryIn[gi] : flagQ[2+2*gi];
      assign flagLoop[3+2*gi] = ctl.idxZeroLd[gi]  ? idxZeroIn[gi]  : flagQ[3+2*gi];
    end
  endgenerate

  assign flagNext = ctl.popLoad ? extBusIn[FLAG_W-1:0] : flagLoop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagNext;
  end

  assign extBusOut = ctl.flagDrive ? {{(DATA_W-FLAG_W){1'b0}}, flagQ} : intBus;
  assign flags     = flagQ;

  // R7: restore takes the low bus bits
  assert_restore_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.popLoad |=> (flagQ == $past(extBusIn[FLAG_W-1:0])));

  // R3: carry from the extended result
  assert_carry_msb_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.aCarrySel == CSEL_MSB && !ctl.popLoad) |=> (flagQ[0] == $past(aSum[SUM_W-1])));

  // R2: accumulator zero follows its indication
  assert_zero_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.aZeroLd && !ctl.popLoad) |=> (flagQ[1] == $past(aZeroIn)));

  // R4: nothing selected means nothing changes
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.aZeroLd && ctl.aCarrySel == CSEL_HOLD && ctl.idxCarryLd == '0 &&
     ctl.idxZeroLd == '0 && !ctl.popLoad) |=> $stable(flagQ));

  // R6: the high bus bits are clear while flags drive it
  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flagDrive |-> (extBusOut[DATA_W-1:FLAG_W] == '0));
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] opWord,
  input  logic [17:0] aSum,
  input  logic        aZeroIn,
  input  logic [2:0]  idxCarryIn,
  input  logic [2:0]  idxZeroIn,
  input  logic [15:0] intBus,
  input  logic [15:0] extBusIn,
  output logic [15:0] extBusOut,
  output logic        flagDrive,
  output logic [7:0]  flags
);
  flagCtl_t ctl;

  flag_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opWord (opWord),
    .ctl    (ctl)
  );

  flag_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .aSum       (aSum),
    .aZeroIn    (aZeroIn),
    .idxCarryIn (idxCarryIn),
    .idxZeroIn  (idxZeroIn),
    .intBus     (intBus),
    .extBusIn   (extBusIn),
    .extBusOut  (extBusOut),
    .flags      (flags)
  );

  assign flagDrive = ctl.flagDrive;
endmodule

// File: tb/flag_unit_tb.sv
module flag_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opWord = '0;
  logic [17:0] aSum = '0;
  logic        aZeroIn = 1'b0;
  logic [2:0]  idxCarryIn = '0;
  logic [2:0]  idxZeroIn = '0;
  logic [15:0] intBus = '0;
  logic [15:0] extBusIn = '0;
  logic [15:0] extBusOut;
  logic        flagDrive;
  logic [7:0]  flags;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] model = '0;

  always #2.5 clk = ~clk;

  flag_unit u_dut (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference for one clock edge
  function automatic logic [7:0] nextModel(input logic [7:0] cur);
    logic [7:0] n = cur;
    int a = int'(opWord[12:9]);
    if (opWord == 16'h0005) return extBusIn[7:0];
    if (a != 0 && a != 1) n[1] = aZeroIn;
    if (a == 3 || a == 4) n[0] = aSum[17];
    else if (a == 5) n[0] = aSum[0];
    for (int i = 0; i < 3; i++) begin
      int f = int'((opWord >> (3 * (2 - i))) & 16'h7);
      if (f == 3) begin n[2+2*i] = idxCarryIn[i]; n[3+2*i] = idxZeroIn[i]; end
      else if (f == 2) n[3+2*i] = idxZeroIn[i];
    end
    return n;
  endfunction

  task automatic step(input logic [15:0] op, input string tag);
    logic save;
    opWord     = op;
    aSum       = 18'($urandom);
    aZeroIn    = 1'($urandom);
    idxCarryIn = 3'($urandom);
    idxZeroIn  = 3'($urandom);
    intBus     = 16'($urandom);
    extBusIn   = 16'($urandom);
    #1;
    save = (op == 16'h0004) || (op == 16'h0006);
    check({tag, " drive"}, {15'd0, flagDrive}, {15'd0, save});
    check({tag, " bus"}, extBusOut, save ? {8'h00, model} : intBus);
    @(posedge clk);
    model = nextModel(model);
    #1;
    check({tag, " flags"}, {8'h00, flags}, {8'h00, model});
  endtask

  initial begin
    #(5.0 * 150000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset flags", {8'h00, flags}, 16'h0000);
    check("R1 reset bus", extBusOut, intBus);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    // R2/R3 accumulator codes
    step(16'h0600, "R3 adc");
    step(16'h0800, "R3 slc");
    step(16'h0A00, "R3 src");
    step(16'h0400, "R2 lda");
    step(16'h0200, "R2 sta hold");
    step(16'h0000, "R2 noa hold");
    step(16'h0E00, "R3 other hold");
    // R4 index compare, load, hold
    step(16'h00DB, "R4 cmp all");
    step(16'h0092, "R4 load all");
    step(16'h0124, "R4 other hold");
    // R5 seven flags at once
    step(16'h0C00 | 16'h00DB, "R5 xor+cmp");
    step(16'h0C00 | 16'h00DB, "R5 xor+cmp again");
    // R6/R7 stack transfers
    step(16'h0004, "R6 pushf");
    step(16'h0006, "R6 ftos");
    step(16'h0005, "R7 popf");
    step(16'h0004, "R6 pushf after pop");
    step(16'h0005, "R7 popf second");
    step(16'h0006, "R6 ftos after pop");
    // R8 near misses
    step(16'h0204, "R8 push with sta");
    step(16'h2005, "R8 pop with p");
    step(16'h0045, "R8 pop with x");
    step(16'h0085, "R8 pop with ldx");
    step(16'h8006, "R8 ftos with p");
    for (int k = 0; k < 400; k++) begin
      logic [15:0] w;
      case ($urandom_range(0, 5))
        0: w = 16'h0004 + 16'($urandom_range(0, 2));
        1: w = (16'h0004 + 16'($urandom_range(0, 2))) ^ (16'h1 << $urandom_range(3, 15));
        default: w = 16'($urandom);
      endcase
      step(w, "R4 mixed");
    end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule